// File: doc/BRIEF.md
# Virtual PE Mapping Command Handler

This block sits behind the command queue front end of an interrupt translation unit. The front end presents one command as four 64-bit doublewords. The handler claims only the command that binds a virtual processing element (vPE) to a redistributor. It pulls out the vPE number, the redistributor index, a valid flag and the size and address of the virtual pending table. It checks these against the configured limits. When they pass, it packs a 64-bit vPE table entry and stores it through a request/response memory port. A one-cycle done pulse then tells the queue sequencer whether to continue or to stall.

A command that fails a check is dropped without any memory traffic and still reports continue. The checks run in a fixed order: the virtual feature enable, then the table size, then the redistributor index, then the vPE range. The first check that fails ends the command. The vPE table is either flat or two-level. In two-level mode a level-1 pointer word is read first. If that word holds no valid page, the store is dropped and the result is continue. Only a memory fault, on the level-1 read or on the store, makes the handler report stall.

Top module: `vpe_map_cmd`

## Requirements
- R1: Only a command whose opcode byte (doubleword 0 bits [7:0]) equals 0x29 is processed. Any other opcode causes no memory request and no done pulse.
- R2: With `cfg_virt_en` low, a 0x29 command gives a done pulse with `done_stall`=0 and makes no memory request.
- R3: The table size is doubleword 3 bits [7:0]. If it is greater than `cfg_id_bits`, the command is dropped with continue and no memory request. A size equal to `cfg_id_bits` is accepted.
- R4: The valid flag is doubleword 2 bit 63 and the redistributor index is doubleword 2 bits [51:16]. With the flag set, an index at or above `cfg_num_cpus` drops the command with continue. With the flag clear, the index is not checked.
- R5: The vPE number is doubleword 1 bits [47:32]. A value at or above `cfg_tbl_entries` drops the command with continue. The value `cfg_tbl_entries`-1 is accepted.
- R6: The stored entry has the valid flag at bit 63, the size bits [5:0] at bits [62:57], zero at [56:52], the index bits [15:0] at [51:36] and the 36-bit address field (doubleword 3 bits [51:16]) at [35:0]. When the valid flag is clear, the stored entry is all zeros. All bits of the command not named above are ignored.
- R7: With `cfg_two_level` low, the single 64-bit store goes to `cfg_tbl_base` + 8 x vPE.
- R8: With `cfg_two_level` high, a read is issued at `cfg_tbl_base` + 8 x (vPE / 512). If bit 63 of the returned word is clear, there is no store and the result is continue. Otherwise the store goes to (returned word bits [51:12] with 12 zero bits appended) + 8 x (vPE mod 512).
- R9: An error response to the level-1 read or to the store gives a done pulse with `done_stall`=1. A store with no error gives `done_stall`=0.
- R10: After reset `cmd_ready`=1, `done_valid`=0 and `mem_req_valid`=0. `cmd_ready` is low from acceptance until the done pulse. `done_valid` is high for exactly one cycle per processed command.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Handler idle, command taken on valid |
| cmd_dw0 | input | 64 | Command doubleword 0 (opcode in [7:0]) |
| cmd_dw1 | input | 64 | Command doubleword 1 (vPE number) |
| cmd_dw2 | input | 64 | Command doubleword 2 (valid flag, redistributor index) |
| cmd_dw3 | input | 64 | Command doubleword 3 (table size and address) |
| cfg_virt_en | input | 1 | Virtual interrupt feature enable |
| cfg_id_bits | input | IDB_W | Largest allowed table size value |
| cfg_num_cpus | input | CPU_W | Number of redistributors |
| cfg_tbl_entries | input | 17 | vPE table entry count |
| cfg_tbl_base | input | ADDR_W | vPE table base byte address |
| cfg_two_level | input | 1 | Two-level table mode |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 64 | Store data, little-endian word |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Response carries a fault |
| mem_rsp_rdata | input | 64 | Load data |
| done_valid | output | 1 | Command finished, one cycle |
| done_stall | output | 1 | 0 continue, 1 stall |

## Verification
The assertions assume that memory returns exactly one response per accepted request, never before the cycle that follows acceptance. They also assume that the configuration inputs do not change while a command is in flight. The bench memory model answers one cycle after each handshake and holds `mem_req_ready` low for one cycle on every request, so the hold rule is exercised. The bench changes the configuration only while the handler is idle and no expectations are pending.

// File: rtl/vpe_map_pkg.sv
package vpe_map_pkg;

  localparam logic [7:0] OPC_VPE_MAP = 8'h29;
  localparam int VPE_ID_W = 16;
  localparam int RD_IDX_W = 36;
  localparam int PT_ADR_W = 36;
  localparam int PT_SZ_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_L1_REQ, ST_L1_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_DONE
  } map_state_e;

  typedef enum logic [2:0] {
    VD_PASS, VD_NOFEAT, VD_SIZE, VD_RDIDX, VD_RANGE
  } verdict_e;

  typedef struct packed {
    logic [VPE_ID_W-1:0] vpe_id;
    logic [RD_IDX_W-1:0] rd_idx;
    logic                live;
    logic [PT_SZ_W-1:0]  pt_size;
    logic [PT_ADR_W-1:0] pt_addr;
  } map_fields_t;

  function automatic logic [7:0] opcode_of(input logic [63:0] w0);
    return w0[7:0];
  endfunction

  function automatic map_fields_t extract_fields(input logic [63:0] w1,
                                                 input logic [63:0] w2,
                                                 input logic [63:0] w3);
    map_fields_t f;
    f.vpe_id  = w1[47:32];
    f.rd_idx  = w2[51:16];
    f.live    = w2[63];
    f.pt_size = w3[7:0];
    f.pt_addr = w3[51:16];
    return f;
  endfunction

  // Entry layout: [63] live, [62:57] size, [56:52] zero, [51:36] index, [35:0] address
  function automatic logic [63:0] pack_entry(input map_fields_t f);
    logic [63:0] e;
    e = '0;
    if (f.live) begin
      e[63]    = 1'b1;
      e[62:57] = f.pt_size[5:0];
      e[51:36] = f.rd_idx[15:0];
      e[35:0]  = f.pt_addr;
    end
    return e;
  endfunction

endpackage

// File: rtl/vpe_map_check.sv
module vpe_map_check
  import vpe_map_pkg::*;
#(
  parameter int IDB_W = 5,
  parameter int CPU_W = 16
) (
  input  map_fields_t      fields,
  input  logic             virt_en,
  input  logic [IDB_W-1:0] id_bits,
  input  logic [CPU_W-1:0] num_cpus,
  input  logic [VPE_ID_W:0] tbl_entries,
  output verdict_e         verdict,
  output logic             pass
);

  logic size_bad, rd_bad, range_bad;

  assign size_bad  = fields.pt_size > PT_SZ_W'(id_bits);
  assign rd_bad    = fields.live && (fields.rd_idx >= RD_IDX_W'(num_cpus));
  assign range_bad = {1'b0, fields.vpe_id} >= tbl_entries;

  // Fixed order; first failure wins
  always_comb begin
    if (!virt_en)       verdict = VD_NOFEAT;
    else if (size_bad)  verdict = VD_SIZE;
    else if (rd_bad)    verdict = VD_RDIDX;
    else if (range_bad) verdict = VD_RANGE;
    else                verdict = VD_PASS;
  end

  assign pass = (verdict == VD_PASS);

endmodule

// File: rtl/vpe_map_addr.sv
module vpe_map_addr
  import vpe_map_pkg::*;
#(
  parameter int ADDR_W     = 52,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [VPE_ID_W-1:0] vpe_id,
  input  logic [63:0]         l1_word,
  output logic [ADDR_W-1:0]   flat_addr,
  output logic [ADDR_W-1:0]   l1_addr,
  output logic [ADDR_W-1:0]   l2_addr,
  output logic                l1_present
);

  localparam int SLOT_SHIFT = PAGE_SHIFT - 3;
  localparam logic [VPE_ID_W-1:0] SLOT_MASK = VPE_ID_W'((64'd1 << SLOT_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0]   OFF_MASK  = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  function automatic logic [ADDR_W-1:0] page_of(input logic [63:0] w);
    return ADDR_W'(w) & ~OFF_MASK;
  endfunction

  function automatic logic present_of(input logic [63:0] w);
    return w[63];
  endfunction

  function automatic logic [ADDR_W-1:0] slot_bytes(input logic [VPE_ID_W-1:0] idx);
    return ADDR_W'({idx, 3'b000});
  endfunction

  logic [VPE_ID_W-1:0] l1_idx, l2_slot;

  assign l1_idx     = vpe_id >> SLOT_SHIFT;
  assign l2_slot    = vpe_id & SLOT_MASK;
  assign flat_addr  = base + slot_bytes(vpe_id);
  assign l1_addr    = base + slot_bytes(l1_idx);
  assign l2_addr    = page_of(l1_word) + slot_bytes(l2_slot);
  assign l1_present = present_of(l1_word);

endmodule

// File: rtl/vpe_map_cmd.sv
module vpe_map_cmd
  import vpe_map_pkg::*;
#(
  parameter int ADDR_W     = 52,
  parameter int IDB_W      = 5,
  parameter int CPU_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [63:0]       cmd_dw0,
  input  logic [63:0]       cmd_dw1,
  input  logic [63:0]       cmd_dw2,
  input  logic [63:0]       cmd_dw3,
  input  logic              cfg_virt_en,
  input  logic [IDB_W-1:0]  cfg_id_bits,
  input  logic [CPU_W-1:0]  cfg_num_cpus,
  input  logic [16:0]       cfg_tbl_entries,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic              cfg_two_level,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [63:0]       mem_rsp_rdata,
  output logic              done_valid,
  output logic              done_stall
);

  map_state_e        state_q;
  map_fields_t       fields_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic              stall_q;

  verdict_e          verdict;
  logic              pass;
  logic [ADDR_W-1:0] flat_addr, l1_addr, l2_addr;
  logic              l1_present;

  // Named events for the assertions
  logic accept_evt, reject_evt, rsp_fault_evt, l1_miss_evt;

  vpe_map_check #(.IDB_W(IDB_W), .CPU_W(CPU_W)) u_check (
    .fields      (fields_q),
    .virt_en     (cfg_virt_en),
    .id_bits     (cfg_id_bits),
    .num_cpus    (cfg_num_cpus),
    .tbl_entries (cfg_tbl_entries),
    .verdict     (verdict),
    .pass        (pass)
  );

  vpe_map_addr #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .base       (cfg_tbl_base),
    .vpe_id     (fields_q.vpe_id),
    .l1_word    (mem_rsp_rdata),
    .flat_addr  (flat_addr),
    .l1_addr    (l1_addr),
    .l2_addr    (l2_addr),
    .l1_present (l1_present)
  );

  assign accept_evt    = cmd_valid && cmd_ready && (opcode_of(cmd_dw0) == OPC_VPE_MAP);
  assign reject_evt    = (state_q == ST_EVAL) && !pass;
  assign rsp_fault_evt = mem_rsp_valid && mem_rsp_err &&
                         ((state_q == ST_L1_WAIT) || (state_q == ST_WR_WAIT));
  assign l1_miss_evt   = (state_q == ST_L1_WAIT) && mem_rsp_valid && !mem_rsp_err && !l1_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fields_q  <= '0;
      wr_addr_q <= '0;
      stall_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            fields_q <= extract_fields(cmd_dw1, cmd_dw2, cmd_dw3);
            stall_q  <= 1'b0;
            state_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!pass) begin
            stall_q <= 1'b0;
            state_q <= ST_DONE;
          end else if (cfg_two_level) begin
            state_q <= ST_L1_REQ;
          end else begin
            wr_addr_q <= flat_addr;
            state_q   <= ST_WR_REQ;
          end
        end
        ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              stall_q <= 1'b1;
              state_q <= ST_DONE;
            end else if (!l1_present) begin
              stall_q <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              wr_addr_q <= l2_addr;
              state_q   <= ST_WR_REQ;
            end
          end
        end
        ST_WR_REQ: if (mem_req_ready) state_q <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (mem_rsp_valid) begin
            stall_q <= mem_rsp_err;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_addr  = (state_q == ST_L1_REQ) ? l1_addr : wr_addr_q;
  assign mem_req_wdata = pack_entry(fields_q);
  assign done_valid    = (state_q == ST_DONE);
  assign done_stall    = (state_q == ST_DONE) && stall_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !cmd_ready && !done_valid); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R11

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> done_valid && !done_stall && !mem_req_valid); // R3

  AST_NOFEAT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) && !cfg_virt_en |=> done_valid && !done_stall); // R2

  AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && !fields_q.live |-> mem_req_wdata == 64'd0); // R6

  AST_FAULT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_evt |=> done_valid && done_stall); // R9

  AST_L1_MISS_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss_evt |=> done_valid && !done_stall && !mem_req_valid); // R8

endmodule

// File: tb/vpe_map_cmd_tb.sv
`timescale 1ns/1ps
module vpe_map_cmd_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_dw0 = '0, cmd_dw1 = '0, cmd_dw2 = '0, cmd_dw3 = '0;
  logic        cfg_virt_en = 1'b1;
  logic [4:0]  cfg_id_bits = 5'd16;
  logic [15:0] cfg_num_cpus = 16'd4;
  logic [16:0] cfg_tbl_entries = 17'd1000;
  logic [51:0] cfg_tbl_base = 52'h0_0000_0010_0000;
  logic        cfg_two_level = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        done_valid, done_stall;

  always #4 clk = ~clk;

  vpe_map_cmd u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dw0(cmd_dw0), .cmd_dw1(cmd_dw1), .cmd_dw2(cmd_dw2), .cmd_dw3(cmd_dw3),
    .cfg_virt_en(cfg_virt_en), .cfg_id_bits(cfg_id_bits), .cfg_num_cpus(cfg_num_cpus),
    .cfg_tbl_entries(cfg_tbl_entries), .cfg_tbl_base(cfg_tbl_base),
    .cfg_two_level(cfg_two_level), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid), .done_stall(done_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ev_cnt = 0;
  string cur_req = "R10";

  logic [63:0] mem_q [logic [51:0]];
  bit          err_q [logic [51:0]];
  logic [51:0] exp_wr_addr [$];
  logic [63:0] exp_wr_data [$];
  bit          exp_done [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor plus memory model
  initial begin : mon_mem
    bit          prev_hs = 0, prev_wait = 0, prev_done = 0;
    int          wcnt = 0;
    logic [51:0] cap_addr = '0;
    bit          cap_wr = 0;
    logic [63:0] cap_data = '0;
    forever begin
      @(negedge clk);
      if (prev_hs) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = err_q.exists(cap_addr);
        mem_req_ready = 1'b0;
        if (cap_wr) begin
          mem_rsp_rdata = '0;
          if (!mem_rsp_err) mem_q[cap_addr] = cap_data;
        end else begin
          mem_rsp_rdata = mem_q.exists(cap_addr) ? mem_q[cap_addr] : 64'd0;
        end
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end
      if (prev_wait)
        chk(mem_req_valid && mem_req_addr == cap_addr && mem_req_write == cap_wr
            && mem_req_wdata == cap_data, "R11", "request held while not ready",
            {12'h0, mem_req_addr}, {12'h0, cap_addr});
      prev_hs = 0;
      prev_wait = 0;
      if (mem_req_valid) begin
        if (!mem_req_ready) begin
          wcnt++;
          if (wcnt >= 2) mem_req_ready = 1'b1;
        end
        cap_addr = mem_req_addr;
        cap_wr   = mem_req_write;
        cap_data = mem_req_wdata;
        if (mem_req_ready) begin
          prev_hs = 1;
          wcnt = 0;
          if (mem_req_write) begin
            ev_cnt++;
            if (exp_wr_addr.size() == 0) begin
              chk(1'b0, cur_req, "unexpected store", {12'h0, mem_req_addr}, 64'd0);
            end else begin
              logic [51:0] ea;
              logic [63:0] ed;
              ea = exp_wr_addr.pop_front();
              ed = exp_wr_data.pop_front();
              chk(mem_req_addr == ea, cur_req, "store address",
                  {12'h0, mem_req_addr}, {12'h0, ea});
              chk(mem_req_wdata == ed, cur_req, "store data", mem_req_wdata, ed);
            end
          end
        end else begin
          prev_wait = 1;
        end
      end
      if (done_valid) begin
        ev_cnt++;
        chk(!prev_done, "R10", "done pulse longer than one cycle", 64'd1, 64'd0);
        if (exp_done.size() == 0) begin
          chk(1'b0, cur_req, "unexpected done", {63'd0, done_stall}, 64'd0);
        end else begin
          bit es;
          es = exp_done.pop_front();
          chk(done_stall == es, cur_req, "done result", {63'd0, done_stall}, {63'd0, es});
        end
      end
      prev_done = done_valid;
    end
  end

  // Driver: computes expectations from the requirements, then issues the command
  task automatic run_cmd(input string req, input logic [7:0] opc, input logic [15:0] vpe,
                         input logic [35:0] rd, input bit v, input logic [7:0] sz,
                         input logic [35:0] pa);
    logic [63:0] entry, w;
    logic [51:0] a;
    cur_req = req;
    if (opc == 8'h29) begin
      if (!cfg_virt_en || sz > {3'b0, cfg_id_bits} || (v && rd >= {20'h0, cfg_num_cpus})
          || {1'b0, vpe} >= cfg_tbl_entries) begin
        exp_done.push_back(1'b0);
      end else begin
        entry = 64'd0;
        if (v) entry = (64'd1 << 63) | ({58'd0, sz[5:0]} << 57) | ({48'd0, rd[15:0]} << 36)
                       | {28'd0, pa};
        if (!cfg_two_level) begin
          a = cfg_tbl_base + {36'd0, vpe} * 52'd8;
          exp_wr_addr.push_back(a);
          exp_wr_data.push_back(entry);
          exp_done.push_back(err_q.exists(a));
        end else begin
          a = cfg_tbl_base + {36'd0, vpe / 16'd512} * 52'd8;
          if (err_q.exists(a)) begin
            exp_done.push_back(1'b1);
          end else begin
            w = mem_q.exists(a) ? mem_q[a] : 64'd0;
            if (!w[63]) begin
              exp_done.push_back(1'b0);
            end else begin
              a = (w[51:0] / 52'd4096) * 52'd4096 + {36'd0, vpe % 16'd512} * 52'd8;
              exp_wr_addr.push_back(a);
              exp_wr_data.push_back(entry);
              exp_done.push_back(err_q.exists(a));
            end
          end
        end
      end
    end
    while (!cmd_ready) @(negedge clk);
    cmd_dw0 = {56'hDEAD_BEEF_0000_00, opc};
    cmd_dw1 = {16'hA5A5, vpe, 32'h1234_5678};
    cmd_dw2 = {v, 11'h7FF, rd, 16'hBEEF};
    cmd_dw3 = {12'hFFF, pa, 8'h77, sz};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (opc == 8'h29)
      chk(!cmd_ready, "R10", "ready low while busy", {63'd0, cmd_ready}, 64'd0);
    while (exp_done.size() != 0 || exp_wr_addr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int ev0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10", "reset cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk(done_valid == 1'b0, "R10", "reset done_valid", {63'd0, done_valid}, 64'd0);
    chk(mem_req_valid == 1'b0, "R10", "reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);

    // R7 R6: flat store, size equal to limit, highest legal index
    run_cmd("R7", 8'h29, 16'd5, 36'd3, 1'b1, 8'd16, 36'h1_2345_6789);
    // R6 R4: valid clear, index out of range is not checked, zero entry
    run_cmd("R6", 8'h29, 16'd7, 36'd100, 1'b0, 8'd4, 36'h0_FFFF_0000);
    // R3: size above limit
    run_cmd("R3", 8'h29, 16'd8, 36'd1, 1'b1, 8'd17, 36'h0_0000_1000);
    // R3: upper size bits set
    run_cmd("R3", 8'h29, 16'd8, 36'd1, 1'b1, 8'hC2, 36'h0_0000_1000);
    // R4: index equals cpu count
    run_cmd("R4", 8'h29, 16'd8, 36'd4, 1'b1, 8'd2, 36'h0_0000_1000);
    // R5: last legal entry, then first illegal
    run_cmd("R5", 8'h29, 16'd999, 36'd0, 1'b1, 8'd1, 36'h0_ABCD_EF01);
    run_cmd("R5", 8'h29, 16'd1000, 36'd0, 1'b1, 8'd1, 36'h0_ABCD_EF01);
    // R2: feature disabled
    cfg_virt_en = 1'b0;
    run_cmd("R2", 8'h29, 16'd3, 36'd0, 1'b1, 8'd1, 36'h0_0000_2000);
    cfg_virt_en = 1'b1;
    // R1: other opcode, nothing may happen
    ev0 = ev_cnt;
    run_cmd("R1", 8'h2A, 16'd3, 36'd0, 1'b1, 8'd1, 36'h0_0000_2000);
    repeat (8) @(negedge clk);
    chk(ev_cnt == ev0, "R1", "activity for foreign opcode", 64'(ev_cnt), 64'(ev0));
    // R9: flat store fault
    err_q[cfg_tbl_base + 52'd72] = 1'b1;
    run_cmd("R9", 8'h29, 16'd9, 36'd2, 1'b1, 8'd3, 36'h0_0000_3000);

    // Two-level table
    cfg_two_level = 1'b1;
    cfg_tbl_entries = 17'd2000;
    mem_q[cfg_tbl_base + 52'd8] = 64'h8000_0000_0040_0ABC;
    run_cmd("R8", 8'h29, 16'd600, 36'd1, 1'b1, 8'd9, 36'h0_5555_AAAA);
    // R8: level-1 word absent
    run_cmd("R8", 8'h29, 16'd10, 36'd1, 1'b1, 8'd9, 36'h0_5555_AAAA);
    // R8: level-1 word present bit clear
    mem_q[cfg_tbl_base + 52'd24] = 64'h0000_0000_0080_0000;
    run_cmd("R8", 8'h29, 16'd1600, 36'd0, 1'b1, 8'd1, 36'h0_0000_0001);
    // R9: level-1 read fault
    err_q[cfg_tbl_base + 52'd16] = 1'b1;
    run_cmd("R9", 8'h29, 16'd1100, 36'd0, 1'b1, 8'd1, 36'h0_0000_0001);
    // R9: level-2 store fault
    err_q[52'h0_0000_0040_0040] = 1'b1;
    run_cmd("R9", 8'h29, 16'd520, 36'd2, 1'b0, 8'd1, 36'h0_0000_0001);

    chk(exp_done.size() == 0 && exp_wr_addr.size() == 0, "R10", "scoreboard drained",
        64'(exp_done.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule